// File: doc/BRIEF.md
# Memory Bank Target Responder

This block terminates command packets on the memory-bank side of a 65-bit flit network. Bit 64 of every flit is the end-of-packet flag. A command arrives as a header flit that is followed, for a write, by payload flits. The block decodes the header and performs the requested 32-bit word accesses on a local word memory. It then builds the response packet for the requester.

The response header echoes the requester's source identifier in its top 14 bits, so the reply can be routed back. It also echoes the transaction identifier and a 2-bit status. The status encodes both the kind of transaction and whether it succeeded. A read reply carries the data words in flits of two words each.

Input and output both use valid/ready handshakes. The block handles one transaction at a time. While a response is pending, output back-pressure holds the block without dropping or changing a flit. The storage is an internal word array of parameterised depth.

Top module: `tgt_bank_responder`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Command header decode uses these fields (bit 64 is end-of-packet):
  - bits 63:26 are the 38-bit word address.
  - bits 25:24 are unused.
  - bits 23:20 are WLEN, the word count minus one.
  - bits 19:18 are the operation: 00 read, 01 write, 10 or 11 reserved.
  - bits 17:4 are the source identifier.
  - bits 3:0 are the transaction identifier.
- R3: A write is followed by WLEN/2+1 payload flits (integer division). Payload flit j carries word base+2j in bits 31:0 and word base+2j+1 in bits 63:32. When the word count is odd, the upper half of the last flit is not stored.
- R4: A write response is a single flit with end-of-packet set. It has these fields:
  - bits 63:50 hold the echoed source identifier.
  - bits 49:6 are zero.
  - bits 5:4 hold the status.
  - bits 3:0 hold the echoed transaction identifier.

  The status is 10 on success. The response appears only after the last payload flit has been accepted.
- R5: A read response is a header flit, laid out as in R4 with end-of-packet clear and status 00 on success. It is followed by WLEN/2+1 data flits, each with two words and the lower address in bits 31:0. When the word count is odd, the upper half of the last flit is zero. End-of-packet is set on the last data flit only.
- R6: A transaction is out of range when address+WLEN is at least the memory depth.
  - An out-of-range read answers status 01, followed by the normal number of data flits, all zero.
  - An out-of-range write consumes its payload, changes no memory word, and answers status 11.
- R7: A reserved operation code is consumed up to and including the flit with end-of-packet set. It is answered with one flit that carries status 11 and end-of-packet set, and no memory word changes.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_flit` stays stable, and no response flit is lost or repeated. `cmd_ready` is 0 while a response is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command flit valid |
| cmd_ready | output | 1 | Command flit accepted when high with valid |
| cmd_flit | input | 65 | Command flit, bit 64 end-of-packet |
| rsp_valid | output | 1 | Response flit valid |
| rsp_ready | input | 1 | Downstream accepts response flit |
| rsp_flit | output | 65 | Response flit, bit 64 end-of-packet |

## Verification
The main test sweeps the word count through all sixteen WLEN values. Each count is tried at address zero, at the highest address that still fits, and one word past it. This separates correct beat counting and odd-count handling from off-by-one errors in the range check. Each write is read back against a model kept in the bench, which shows whether the word order within a flit and the suppression of the unused upper half are correct. Separately, an address with its top bit set tests the full-width range comparison. Reserved codes are sent as single-flit and multi-flit packets, and a final read of the whole memory confirms that neither they nor the failed writes changed memory. Response stalls of zero, one and two cycles rotate across flits, to test that the output holds stable under back-pressure.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

  localparam int FLIT_W = 65;
  localparam int SRC_W  = 14;
  localparam int TRD_W  = 4;
  localparam int LEN_W  = 4;
  localparam int ADR_W  = 38;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WPAY,
    ST_DRAIN,
    ST_RHDR,
    ST_RDAT
  } eng_state_e;

  function automatic logic [ADR_W-1:0] hdr_addr(input logic [FLIT_W-1:0] f);
    return f[63:26];
  endfunction

  function automatic logic [LEN_W-1:0] hdr_wlen(input logic [FLIT_W-1:0] f);
    return f[23:20];
  endfunction

  function automatic logic [1:0] hdr_op(input logic [FLIT_W-1:0] f);
    return f[19:18];
  endfunction

  function automatic logic [SRC_W-1:0] hdr_src(input logic [FLIT_W-1:0] f);
    return f[17:4];
  endfunction

  function automatic logic [TRD_W-1:0] hdr_trd(input logic [FLIT_W-1:0] f);
    return f[3:0];
  endfunction

  // Number of two-word flits needed for WLEN+1 words.
  function automatic logic [LEN_W-1:0] beat_count(input logic [LEN_W-1:0] wlen);
    return {1'b0, wlen[LEN_W-1:1]} + LEN_W'(1);
  endfunction

  // Status: upper bit set for anything that is not a read, lower bit for failure.
  function automatic logic [1:0] status_code(input logic is_rd, input logic fail);
    return {~is_rd, fail};
  endfunction

  function automatic logic [FLIT_W-1:0] rsp_header(input logic eop,
                                                   input logic [SRC_W-1:0] src,
                                                   input logic [1:0] st,
                                                   input logic [TRD_W-1:0] trd);
    return {eop, src, 44'd0, st, trd};
  endfunction

endpackage

// File: rtl/tgt_word_mem.sv
module tgt_word_mem #(
  parameter  int WORDS = 64,
  parameter  int DW    = 32,
  localparam int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [IW-1:0] wa_a,
  input  logic [DW-1:0] wd_a,
  input  logic          we_b,
  input  logic [IW-1:0] wa_b,
  input  logic [DW-1:0] wd_b,
  input  logic [IW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [IW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we_a) cells[wa_a] <= wd_a;
    if (we_b) cells[wa_b] <= wd_b;
  end

  assign rd_a = cells[ra_a];
  assign rd_b = cells[ra_b];

  // R3
  dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |-> (wa_a != wa_b));

endmodule

// File: rtl/tgt_cmd_engine.sv
module tgt_cmd_engine
  import tgt_pkg::*;
#(
  parameter  int MEM_WORDS = 64,
  localparam int IW        = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [FLIT_W-1:0] cmd_flit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [FLIT_W-1:0] rsp_flit,
  output logic              mem_we_a,
  output logic [IW-1:0]     mem_wa_a,
  output logic [WORD_W-1:0] mem_wd_a,
  output logic              mem_we_b,
  output logic [IW-1:0]     mem_wa_b,
  output logic [WORD_W-1:0] mem_wd_b,
  output logic [IW-1:0]     mem_ra_a,
  input  logic [WORD_W-1:0] mem_rd_a,
  output logic [IW-1:0]     mem_ra_b,
  input  logic [WORD_W-1:0] mem_rd_b
);

  eng_state_e        state_q;
  logic [SRC_W-1:0]  src_q;
  logic [TRD_W-1:0]  trd_q;
  logic [LEN_W-1:0]  wlen_q;
  logic [IW-1:0]     base_q;
  logic              fail_q;
  logic              is_rd_q;
  logic [LEN_W-2:0]  beat_q;

  // Named internal events.
  logic hdr_fire, pay_fire, drn_fire, rsp_fire, last_beat, hi_used;
  logic [LEN_W-1:0] nbeats;
  logic [IW-1:0]    idx_lo, idx_hi;
  logic [ADR_W:0]   end_addr;
  logic             oor, op_rsvd;

  assign cmd_ready = (state_q == ST_IDLE) || (state_q == ST_WPAY) || (state_q == ST_DRAIN);
  assign rsp_valid = (state_q == ST_RHDR) || (state_q == ST_RDAT);

  assign hdr_fire = cmd_valid && cmd_ready && (state_q == ST_IDLE);
  assign pay_fire = cmd_valid && cmd_ready && (state_q == ST_WPAY);
  assign drn_fire = cmd_valid && cmd_ready && (state_q == ST_DRAIN);
  assign rsp_fire = rsp_valid && rsp_ready;

  assign nbeats    = beat_count(wlen_q);
  assign last_beat = ({1'b0, beat_q} == nbeats - LEN_W'(1));
  assign hi_used   = ({beat_q, 1'b1} <= wlen_q);

  assign idx_lo = base_q + IW'({beat_q, 1'b0});
  assign idx_hi = idx_lo + IW'(1);

  assign end_addr = {1'b0, hdr_addr(cmd_flit)} + (ADR_W+1)'(hdr_wlen(cmd_flit));
  assign oor      = end_addr >= (ADR_W+1)'(MEM_WORDS);
  assign op_rsvd  = hdr_op(cmd_flit)[1];

  // Memory access.
  assign mem_we_a = pay_fire && !fail_q;
  assign mem_we_b = pay_fire && !fail_q && hi_used;
  assign mem_wa_a = idx_lo;
  assign mem_wa_b = idx_hi;
  assign mem_wd_a = cmd_flit[31:0];
  assign mem_wd_b = cmd_flit[63:32];
  assign mem_ra_a = idx_lo;
  assign mem_ra_b = idx_hi;

  logic [WORD_W-1:0] dat_lo, dat_hi;
  assign dat_lo = fail_q ? '0 : mem_rd_a;
  assign dat_hi = (fail_q || !hi_used) ? '0 : mem_rd_b;

  always_comb begin
    if (state_q == ST_RDAT)
      rsp_flit = {last_beat, dat_hi, dat_lo};
    else
      rsp_flit = rsp_header(~is_rd_q, src_q, status_code(is_rd_q, fail_q), trd_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      trd_q   <= '0;
      wlen_q  <= '0;
      base_q  <= '0;
      fail_q  <= 1'b0;
      is_rd_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (hdr_fire) begin
          src_q   <= hdr_src(cmd_flit);
          trd_q   <= hdr_trd(cmd_flit);
          wlen_q  <= hdr_wlen(cmd_flit);
          base_q  <= IW'(hdr_addr(cmd_flit));
          beat_q  <= '0;
          is_rd_q <= (hdr_op(cmd_flit) == OP_READ);
          fail_q  <= op_rsvd || oor;
          if (hdr_op(cmd_flit) == OP_READ)       state_q <= ST_RHDR;
          else if (hdr_op(cmd_flit) == OP_WRITE) state_q <= ST_WPAY;
          else if (cmd_flit[64])                 state_q <= ST_RHDR;
          else                                   state_q <= ST_DRAIN;
        end
        ST_WPAY: if (pay_fire) begin
          if (last_beat) begin
            beat_q  <= '0;
            state_q <= ST_RHDR;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_DRAIN: if (drn_fire && cmd_flit[64]) state_q <= ST_RHDR;
        ST_RHDR: if (rsp_fire) state_q <= is_rd_q ? ST_RDAT : ST_IDLE;
        ST_RDAT: if (rsp_fire) begin
          if (last_beat) state_q <= ST_IDLE;
          else           beat_q  <= beat_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_flit)));

  // R8
  serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && rsp_valid));

  // R5
  rd_hdr_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && state_q == ST_RHDR && is_rd_q) |-> !rsp_flit[64]);

  // R4
  pkt_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && rsp_flit[64]) |=> (!rsp_valid && cmd_ready));

  // R5
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDAT || state_q == ST_WPAY) |-> ({1'b0, beat_q} < nbeats));

  // R6
  fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_fire && oor) |=> !mem_we_a);

endmodule

// File: rtl/tgt_bank_responder.sv
module tgt_bank_responder
  import tgt_pkg::*;
#(
  parameter  int MEM_WORDS = 64,
  localparam int IW        = $clog2(MEM_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [64:0] cmd_flit,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [64:0] rsp_flit
);

  logic              we_a, we_b;
  logic [IW-1:0]     wa_a, wa_b, ra_a, ra_b;
  logic [WORD_W-1:0] wd_a, wd_b, rd_a, rd_b;

  tgt_cmd_engine #(.MEM_WORDS(MEM_WORDS)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_flit (cmd_flit),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_flit (rsp_flit),
    .mem_we_a (we_a),
    .mem_wa_a (wa_a),
    .mem_wd_a (wd_a),
    .mem_we_b (we_b),
    .mem_wa_b (wa_b),
    .mem_wd_b (wd_b),
    .mem_ra_a (ra_a),
    .mem_rd_a (rd_a),
    .mem_ra_b (ra_b),
    .mem_rd_b (rd_b)
  );

  tgt_word_mem #(.WORDS(MEM_WORDS), .DW(WORD_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we_a (we_a),
    .wa_a (wa_a),
    .wd_a (wd_a),
    .we_b (we_b),
    .wa_b (wa_b),
    .wd_b (wd_b),
    .ra_a (ra_a),
    .rd_a (rd_a),
    .ra_b (ra_b),
    .rd_b (rd_b)
  );

endmodule

// File: tb/tb_tgt_bank_responder.sv
`timescale 1ns/1ps
module tb_tgt_bank_responder;

  localparam int WORDS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [64:0] cmd_flit = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [64:0] rsp_flit;

  always #2 clk = ~clk;

  tgt_bank_responder #(.MEM_WORDS(WORDS)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_flit(cmd_flit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_flit(rsp_flit)
  );

  int n_chk = 0;
  int n_fail = 0;
  int stall_sel = 0;
  int seq = 1;
  logic [31:0] model [WORDS];

  task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [64:0] mk_cmd(input logic eop, input logic [37:0] a, input logic [3:0] wl,
                                         input logic [1:0] op, input logic [13:0] s, input logic [3:0] t);
    return {eop, a, 2'b00, wl, op, s, t};
  endfunction

  function automatic logic [64:0] exp_hdr(input logic eop, input logic [13:0] s,
                                          input logic [1:0] st, input logic [3:0] t);
    logic [64:0] h;
    h = '0;
    h[64] = eop; h[63:50] = s; h[5:4] = st; h[3:0] = t;
    return h;
  endfunction

  function automatic logic [31:0] gen_word(input int n);
    return 32'h9E3779B9 * n + 32'h00C0FFEE;
  endfunction

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic push(input logic [64:0] f);
    bit rdy;
    cmd_valid = 1'b1;
    cmd_flit  = f;
    forever begin
      rdy = cmd_ready;
      @(negedge clk);
      if (rdy) break;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic pull(output logic [64:0] f);
    int st;
    st = stall_sel % 3;
    stall_sel++;
    rsp_ready = 1'b0;
    while (!rsp_valid) @(negedge clk);
    f = rsp_flit;
    repeat (st) begin
      @(negedge clk);
      check(rsp_valid && rsp_flit == f, "R8 stall hold", rsp_flit, f);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic bit out_of_range(input longint a, input int wl);
    return (a + wl) >= WORDS;
  endfunction

  task automatic do_write(input logic [37:0] a, input int wl, input logic [13:0] s, input logic [3:0] t);
    logic [64:0] f;
    bit bad;
    int nb;
    logic [31:0] lo, hi;
    bad = out_of_range(longint'(a), wl);
    nb = wl / 2 + 1;
    push(mk_cmd(1'b0, a, 4'(wl), 2'b01, s, t));
    for (int j = 0; j < nb; j++) begin
      lo = gen_word(seq++);
      hi = gen_word(seq++);
      check(!rsp_valid, "R4 no early response", {64'd0, rsp_valid}, 65'd0);
      push({(j == nb - 1), hi, lo});
      if (!bad) begin
        model[int'(a) + 2*j] = lo;
        if (2*j + 1 <= wl) model[int'(a) + 2*j + 1] = hi;
      end
    end
    pull(f);
    check(f == exp_hdr(1'b1, s, {1'b1, bad}, t), bad ? "R6 write error header" : "R4 write header",
          f, exp_hdr(1'b1, s, {1'b1, bad}, t));
    check(!rsp_valid && cmd_ready, "R4 single flit", {63'd0, rsp_valid, cmd_ready}, 65'd1);
  endtask

  task automatic do_read(input logic [37:0] a, input int wl, input logic [13:0] s, input logic [3:0] t);
    logic [64:0] f, e;
    bit bad;
    int nb;
    bad = out_of_range(longint'(a), wl);
    nb = wl / 2 + 1;
    push(mk_cmd(1'b1, a, 4'(wl), 2'b00, s, t));
    pull(f);
    e = exp_hdr(1'b0, s, {1'b0, bad}, t);
    check(f == e, bad ? "R6 read error header" : "R2 R5 read header", f, e);
    for (int j = 0; j < nb; j++) begin
      pull(f);
      e = '0;
      e[64] = (j == nb - 1);
      if (!bad) begin
        e[31:0] = model[int'(a) + 2*j];
        if (2*j + 1 <= wl) e[63:32] = model[int'(a) + 2*j + 1];
      end
      check(f == e, bad ? "R6 read zero data" : "R3 R5 read data", f, e);
    end
    check(!rsp_valid && cmd_ready, "R5 packet end", {63'd0, rsp_valid, cmd_ready}, 65'd1);
  endtask

  task automatic do_rsvd(input logic [1:0] op, input int extra, input logic [13:0] s, input logic [3:0] t);
    logic [64:0] f;
    push(mk_cmd(extra == 0, 38'd0, 4'd3, op, s, t));
    for (int j = 0; j < extra; j++) push({(j == extra - 1), 32'hDEAD0000, 32'h0000BEEF});
    pull(f);
    check(f == exp_hdr(1'b1, s, 2'b11, t), "R7 reserved reply", f, exp_hdr(1'b1, s, 2'b11, t));
    check(!rsp_valid && cmd_ready, "R7 single flit", {63'd0, rsp_valid, cmd_ready}, 65'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(cmd_ready && !rsp_valid, "R1 reset state", {63'd0, cmd_ready, rsp_valid}, 65'd2);

    // Fill the whole memory so every read has a defined expectation (R3).
    for (int a = 0; a < WORDS; a += 16) do_write(38'(a), 15, 14'h0001, 4'h1);
    do_read(38'd0, 15, 14'h3FFF, 4'hF);

    // WLEN sweep at low, top-fitting and one-past addresses (R3 R5 R6).
    for (int wl = 0; wl < 16; wl++) begin
      do_write(38'd0, wl, 14'(wl * 977), 4'(wl));
      do_read(38'd0, wl, 14'(wl * 31 + 5), 4'(15 - wl));
      do_write(38'(WORDS - 1 - wl), wl, 14'h2AAA, 4'h5);
      do_read(38'(WORDS - 1 - wl), wl, 14'h1555, 4'hA);
      do_write(38'(WORDS - wl), wl, 14'h0F0F, 4'h3);
      do_read(38'(WORDS - wl), wl, 14'h30F0, 4'hC);
    end

    // Full-width address compare (R6).
    do_write(38'h20_0000_0001, 1, 14'h2001, 4'h7);
    do_read(38'h20_0000_0001, 1, 14'h2002, 4'h8);

    // Reserved codes, single and multi-flit (R7).
    do_rsvd(2'b10, 0, 14'h0123, 4'h2);
    do_rsvd(2'b11, 3, 14'h3210, 4'h9);
    do_rsvd(2'b11, 0, 14'h1111, 4'h4);

    // Nothing above changed memory unexpectedly (R6 R7).
    do_read(38'd0, 15, 14'h0ABC, 4'h6);
    do_read(38'd16, 15, 14'h0CBA, 4'hE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule